// File: doc/BRIEF.md
# Stop-Clock Throttling Duty Timer

This block slows a processor by pulsing its active-low stop-clock request in a repeating duty cycle. Software programs two duration registers, one for the asserted phase and one for the negated phase, and sets an enable bit to start throttling. Both durations are counted in pulses of a slow timebase tick, not in system clock cycles.

A single counter serves both phases. It is reloaded each time the output changes level. In the asserted phase, the counter is loaded when the request is driven low. It then waits for the processor's stop-grant acknowledge pulse before it starts counting down. In the negated phase, counting starts at once. Clearing the enable bit releases the request and idles the timer.

Top module: `stop_clock_throttle`

## Requirements
- R1: After synchronous reset, `stpclk_n_o` is 1 and all three registers read back as 0.
- R2: Register addresses are: 0 for the asserted-phase duration, 1 for the negated-phase duration, and 2 for control, where bit 0 is the enable bit. Addresses 0 and 1 read back the full written value. Address 2 reads back the enable bit in bit 0 and zeros above it. Address 3 always reads 0. Read data is combinational on `reg_addr`.
- R3: One clock after the enable bit becomes 1, `stpclk_n_o` goes to 0 and the counter is loaded from the asserted-phase register.
- R4: While asserted and waiting for acknowledge, ticks have no effect. The output stays 0 until a cycle with `grant_i` high, and counting starts on the cycle after that.
- R5: Once counting, the asserted phase lasts value+1 ticks. On the clock edge that samples the tick with the counter at 0, `stpclk_n_o` becomes 1 and the counter is loaded from the negated-phase register.
- R6: The negated phase lasts value+1 ticks. Counting starts immediately, with no acknowledge needed. It ends with the output going to 0, a load from the asserted-phase register, and a new wait for acknowledge.
- R7: A duration of 0 gives a phase of exactly one tick.
- R8: While the enable bit is 0, `stpclk_n_o` is 1 from the next clock onward, and ticks and grants have no effect.
- R9: A write to a duration register does not change a phase already in progress. The new value is used at the next load.
- R10: A grant pulse is ignored when it arrives during the negated phase or after the asserted phase has started counting.
- R11: In a cycle without `tick_i`, a counting phase neither advances nor ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data |
| tick_i | input | 1 | Single-cycle timebase pulse |
| grant_i | input | 1 | Single-cycle stop-grant acknowledge pulse |
| stpclk_n_o | output | 1 | Stop-clock request, active low, registered |

## Verification
The bench builds the block with the default W=8. It programs durations from 0 to small values, so many full duty cycles fit in a short run, and it also takes one pass at 255 to reach the counter's widest reload. In the random section, the tick is driven on about half the cycles and grants arrive at random. This places grants in every phase and ticks right next to reloads. Register writes and enable toggles land in the middle of phases.

// File: rtl/stop_clock_throttle.sv
module stop_clock_throttle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         tick_i,
  input  logic         grant_i,
  output logic         stpclk_n_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] dur_lo, dur_hi, cnt;
  logic         en, run, waiting, out_n;

  assign stpclk_n_o = out_n;
  assign reg_rdata  = (reg_addr == 2'd0) ? dur_lo :
                      (reg_addr == 2'd1) ? dur_hi :
                      (reg_addr == 2'd2) ? {{(W-1){1'b0}}, en} : ZERO;

  wire expire = tick_i && (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_lo  <= ZERO;
      dur_hi  <= ZERO;
      en      <= 1'b0;
      run     <= 1'b0;
      cnt     <= ZERO;
      waiting <= 1'b0;
      out_n   <= 1'b1;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0:    dur_lo <= reg_wdata;
          2'd1:    dur_hi <= reg_wdata;
          2'd2:    en     <= reg_wdata[0];
          default: ;
        endcase
      end
      run <= en;
      if (!en) begin
        out_n   <= 1'b1;
        cnt     <= ZERO;
        waiting <= 1'b0;
      end else if (!run) begin
        out_n   <= 1'b0;
        cnt     <= dur_lo;
        waiting <= 1'b1;
      end else if (!out_n) begin
        if (waiting) begin
          if (grant_i) waiting <= 1'b0;
        end else if (expire) begin
          out_n <= 1'b1;
          cnt   <= dur_hi;
        end else if (tick_i) begin
          cnt <= cnt - 1'b1;
        end
      end else if (expire) begin
        out_n   <= 1'b0;
        cnt     <= dur_lo;
        waiting <= 1'b1;
      end else if (tick_i) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !run) |=> (!stpclk_n_o && cnt == $past(dur_lo)));

  p_hold_for_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (en && run && !out_n && waiting && !grant_i) |=> (!stpclk_n_o && $stable(cnt)));

  p_end_assert_r5: assert property (@(posedge clk) disable iff (rst)
    (en && run && !out_n && !waiting && expire) |=> (stpclk_n_o && cnt == $past(dur_hi)));

  p_end_negate_r6: assert property (@(posedge clk) disable iff (rst)
    (en && run && out_n && expire) |=> (!stpclk_n_o && waiting));

  p_disabled_high_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> stpclk_n_o);

  p_no_tick_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (en && run && !waiting && !tick_i) |=> ($stable(cnt) && $stable(stpclk_n_o)));
endmodule

// File: tb/sim_stop_clock_throttle.sv
module sim_stop_clock_throttle;
  localparam int PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         tick_i = 1'b0;
  logic         grant_i = 1'b0;
  logic         stpclk_n_o;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  stop_clock_throttle #(.W(W)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
    .grant_i(grant_i), .stpclk_n_o(stpclk_n_o)
  );

  // reference state built from the requirements
  logic [W-1:0] m_lo, m_hi, m_cnt;
  logic m_en, m_run, m_wait, m_out;

  function automatic logic [W-1:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return m_lo;
      2'd1:    return m_hi;
      2'd2:    return {{(W-1){1'b0}}, m_en};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] lo, hi;
    logic en;
    lo = m_lo; hi = m_hi; en = m_en;
    if (rst) begin
      m_lo = '0; m_hi = '0; m_en = 0; m_run = 0; m_cnt = '0; m_wait = 0; m_out = 1;
    end else begin
      if (reg_we && reg_addr == 2'd0) m_lo = reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_hi = reg_wdata;
      if (reg_we && reg_addr == 2'd2) m_en = reg_wdata[0];
      if (!en) begin
        m_out = 1; m_cnt = '0; m_wait = 0;
      end else if (!m_run) begin
        m_out = 0; m_cnt = lo; m_wait = 1;
      end else if (m_out == 0 && m_wait) begin
        if (grant_i) m_wait = 0;
      end else if (tick_i) begin
        if (m_cnt == '0) begin
          if (m_out == 0) begin m_out = 1; m_cnt = hi; end
          else begin m_out = 0; m_cnt = lo; m_wait = 1; end
        end else m_cnt = m_cnt - 1'b1;
      end
      m_run = en;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tag, {{(W-1){1'b0}}, stpclk_n_o}, {{(W-1){1'b0}}, m_out});
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic ticks(int n, logic g);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; grant_i = g;
      step();
    end
    tick_i = 0; grant_i = 0;
  endtask

  task automatic grant();
    grant_i = 1; step(); grant_i = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (2) @(negedge clk);
    rst = 0;
    tag = "R1";
    step();
    check("R1", {{(W-1){1'b0}}, stpclk_n_o}, 1);
    for (int a = 0; a < 3; a++) begin
      reg_addr = a[1:0]; #1;
      check("R1", reg_rdata, '0);
    end

    tag = "R2";
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFE); wr(2'd3, 8'h77);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0]; #1;
      check("R2", reg_rdata, exp_read(a[1:0]));
    end

    tag = "R3";
    wr(2'd0, 8'd3); wr(2'd1, 8'd2);
    wr(2'd2, 8'd1);
    step();
    check("R3", {{(W-1){1'b0}}, stpclk_n_o}, 0);

    tag = "R4";
    ticks(12, 0);
    check("R4", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    grant();

    tag = "R5";
    ticks(3, 0);
    check("R5", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    ticks(1, 0);
    check("R5", {{(W-1){1'b0}}, stpclk_n_o}, 1);

    tag = "R11";
    repeat (10) step();
    check("R11", {{(W-1){1'b0}}, stpclk_n_o}, 1);

    tag = "R10";
    ticks(2, 1);
    check("R10", {{(W-1){1'b0}}, stpclk_n_o}, 1);
    ticks(1, 0);
    check("R6", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    grant();
    ticks(2, 1);
    check("R10", {{(W-1){1'b0}}, stpclk_n_o}, 0);

    tag = "R9";
    wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    ticks(1, 0);
    check("R9", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    ticks(1, 0);
    check("R9", {{(W-1){1'b0}}, stpclk_n_o}, 1);

    tag = "R7";
    ticks(1, 0);
    check("R7", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    grant();
    ticks(1, 0);
    check("R7", {{(W-1){1'b0}}, stpclk_n_o}, 1);

    tag = "R6";
    wr(2'd1, 8'd255);
    ticks(1, 0);
    check("R6", {{(W-1){1'b0}}, stpclk_n_o}, 0);
    grant();
    ticks(1, 0);
    ticks(255, 0);
    check("R6", {{(W-1){1'b0}}, stpclk_n_o}, 1);
    ticks(1, 0);
    check("R6", {{(W-1){1'b0}}, stpclk_n_o}, 0);

    tag = "R8";
    wr(2'd2, 8'd0);
    step();
    check("R8", {{(W-1){1'b0}}, stpclk_n_o}, 1);
    ticks(20, 1);
    check("R8", {{(W-1){1'b0}}, stpclk_n_o}, 1);

    tag = "R5";
    wr(2'd1, 8'd2);
    wr(2'd2, 8'd1);
    for (int i = 0; i < 6000; i++) begin
      tick_i  = ($urandom % 2) == 0;
      grant_i = ($urandom % 8) == 0;
      if (($urandom % 40) == 0) begin
        reg_we = 1; reg_addr = 2'($urandom % 4);
        reg_wdata = (reg_addr == 2'd2) ? W'(($urandom % 6) != 0) : W'($urandom % 8);
      end
      step();
      reg_we = 0;
      reg_addr = 2'($urandom % 4); #1;
      check("R2", reg_rdata, exp_read(reg_addr));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule